// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects an internal single-request port to an external asynchronous static RAM of 8K words by 16 bits. The RAM has a shared three-state data bus and two byte write strobes: one for the low byte and one for the high byte. The controller accepts one request at a time while it is idle. A request is a read or a write and carries a 13-bit word address, 16 bits of write data and a 2-bit byte mask. The controller then sequences the chip enable, output enable and byte write strobes, and opens its own data drivers only while the memory outputs are switched off. Each access ends with a one-cycle done pulse; for a read, the captured word is returned at the same time.

All timing is counted in clock cycles and set by parameters: address setup before the strobe, strobe low width, data hold after the strobe, and read access wait. The RAM drops into its own standby whenever chip enable is high, so the controller holds chip enable high for every idle cycle. Because of this, the address pins never change while the RAM is selected.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and after it is released, chip enable, output enable and both write strobes are high (inactive), the data drivers are off, `reqReady` is 1 and `doneValid` is 0.
- R2: A read holds chip enable and output enable low with both write strobes high for ACCESS_CYC cycles. It samples `memDqIn` on the last of these cycles and returns that word on `rspRdata` together with `doneValid`, exactly ACCESS_CYC clock edges after the accepting edge.
- R3: During a write, strobe `memWeN[0]` is low exactly when mask bit 0 is 1 and writes data bits 7:0. Strobe `memWeN[1]` is low exactly when mask bit 1 is 1 and writes bits 15:8. A strobe whose mask bit is 0 stays high.
- R4: A write with a nonzero mask runs three phases: SETUP_CYC cycles with chip enable low and strobes high, then STROBE_CYC cycles with the strobes low, then HOLD_CYC cycles with strobes high and data still driven. `doneValid` rises SETUP_CYC+STROBE_CYC+HOLD_CYC edges after the accepting edge, and the data on the bus does not change while it is driven.
- R5: `memAddr` does not change on any cycle where chip enable stays low, and therefore never while a write strobe is low.
- R6: The data drivers are enabled only while output enable is high. A write strobe is low only while chip enable is low and output enable is high.
- R7: Chip enable is high exactly on the cycles where the controller is idle (`reqReady` = 1).
- R8: `reqReady` is 1 only when idle. Each accepted request produces exactly one `doneValid` pulse, one cycle wide.
- R9: A write whose mask is 2'b00 asserts no strobe and no chip enable. Its `doneValid` appears on the edge that accepts it, and the memory contents stay unchanged.
- R10: `rspRdata` holds the last read word until the next read completes; writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request accepted on this edge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 13 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Byte mask, bit 0 low byte, bit 1 high byte |
| doneValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | 16 | Captured read word |
| memAddr | output | 13 | RAM address pins |
| memCeN | output | 1 | RAM chip enable, active low |
| memOeN | output | 1 | RAM output enable, active low |
| memWeN | output | 2 | RAM byte write strobes, active low |
| memDqOut | output | 16 | Data driven toward the RAM |
| memDqOe | output | 1 | Enable for the data bus drivers |
| memDqIn | input | 16 | Data returned from the RAM bus |

## Verification
The bench runs writes with each mask value, including the empty mask, against an address-keyed memory model that commits bytes on the rising strobe. It then reads them back, so a swapped strobe-to-byte mapping or a write of a masked byte shows up as a wrong merged word. Every access is timed from acceptance to done, which exposes a phase that is one cycle short or long, or a sample of read data taken before the access wait ends. A cycle-by-cycle monitor catches an address that moves while the RAM is selected, drivers opened while output enable is low, chip enable left low while idle, and a done pulse wider than one cycle. A write followed by no read shows whether the read register is disturbed by write traffic.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RACC  = 3'd1,
    ST_WSET  = 3'd2,
    ST_WSTB  = 3'd3,
    ST_WHOLD = 3'd4
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // latch request fields
    logic capture;  // sample the read bus
    logic ceN;
    logic oeN;
    logic strobe;   // byte strobes follow the latched mask
    logic drive;    // open the data drivers
  } strb_t;
endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqMask,
  output logic       reqReady,
  output logic       doneValid,
  output strb_t      strb
);
  localparam int MAX_AB  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_CD  = (HOLD_CYC > ACCESS_CYC) ? HOLD_CYC : ACCESS_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  phase_e state, nextState;
  logic [CNT_W-1:0] cnt;
  int   limit;
  logic lastCyc, finish;

  always_comb begin
    case (state)
      ST_RACC:  limit = ACCESS_CYC;
      ST_WSET:  limit = SETUP_CYC;
      ST_WSTB:  limit = STROBE_CYC;
      ST_WHOLD: limit = HOLD_CYC;
      default:  limit = 1;
    endcase
    lastCyc = (int'(cnt) == limit - 1);
  end

  always_comb begin
    nextState = state;
    finish    = 1'b0;
    case (state)
      ST_IDLE: if (reqValid) begin
        if (!reqWrite)           nextState = ST_RACC;
        else if (reqMask == 2'b00) finish  = 1'b1;
        else                     nextState = ST_WSET;
      end
      ST_RACC:  if (lastCyc) begin nextState = ST_IDLE; finish = 1'b1; end
      ST_WSET:  if (lastCyc) nextState = ST_WSTB;
      ST_WSTB:  if (lastCyc) nextState = ST_WHOLD;
      ST_WHOLD: if (lastCyc) begin nextState = ST_IDLE; finish = 1'b1; end
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      doneValid <= 1'b0;
    end else begin
      state     <= nextState;
      doneValid <= finish;
      if (nextState != state) cnt <= '0;
      else if (state != ST_IDLE) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    reqReady     = (state == ST_IDLE);
    strb.load    = (state == ST_IDLE) && reqValid;
    strb.capture = (state == ST_RACC) && lastCyc;
    strb.ceN     = (state == ST_IDLE);
    strb.oeN     = (state != ST_RACC);
    strb.strobe  = (state == ST_WSTB);
    strb.drive   = (state == ST_WSET) || (state == ST_WSTB) || (state == ST_WHOLD);
  end

  // R4: a strobe only opens after a setup cycle with the bus already driven
  p_setup_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.strobe) |-> $past(strb.drive) && !$past(strb.strobe));
  // R8: completion is reported only once back in idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> reqReady);
  // R7: chip enable only falls after a request was offered
  p_select_on_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.ceN) |-> $past(reqValid));
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ, rdataQ;
  logic [LANES-1:0]  maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      maskQ  <= '0;
      rdataQ <= '0;
    end else begin
      if (strb.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
        maskQ <= reqMask;
      end
      if (strb.capture) rdataQ <= memDqIn;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign memWeN[g] = !(strb.strobe && maskQ[g]);
  end

  assign memAddr  = addrQ;
  assign memDqOut = dataQ;
  assign memDqOe  = strb.drive;
  assign rspRdata = rdataQ;

  // R5: address frozen while the RAM stays selected
  p_addr_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ceN && $past(!strb.ceN)) |-> $stable(memAddr));
  // R6: own drivers never fight the RAM outputs
  p_no_fight_r6: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> strb.oeN);
  // R4: data stays driven in the cycle after the strobes rise
  p_hold_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.strobe) |-> memDqOe && $stable(memDqOut));
  // R3: a low strobe needs the strobe phase
  p_lane_phase_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memWeN != '1) |-> strb.strobe);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [12:0] reqAddr,
  input  logic [15:0] reqWdata,
  input  logic [1:0]  reqMask,
  output logic        doneValid,
  output logic [15:0] rspRdata,
  output logic [12:0] memAddr,
  output logic        memCeN,
  output logic        memOeN,
  output logic [1:0]  memWeN,
  output logic [15:0] memDqOut,
  output logic        memDqOe,
  input  logic [15:0] memDqIn
);
  strb_t strb;

  asram_ctrl_fsm #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC(HOLD_CYC), .ACCESS_CYC(ACCESS_CYC)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMask(reqMask), .reqReady(reqReady), .doneValid(doneValid), .strb(strb)
  );

  asram_datapath #(.ADDR_W(13), .DATA_W(16), .LANES(2)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqMask(reqMask), .memDqIn(memDqIn),
    .rspRdata(rspRdata), .memAddr(memAddr), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe)
  );

  assign memCeN = strb.ceN;
  assign memOeN = strb.oeN;
endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
  localparam int SU = 2, ST = 3, HO = 1, AC = 2;

  typedef struct packed {
    logic        wr;
    logic [12:0] a;
    logic [15:0] d;
    logic [1:0]  m;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 13'h0000, 16'hA5C3, 2'b11},
    '{1'b0, 13'h0000, 16'h0000, 2'b00},
    '{1'b1, 13'h1FFF, 16'h1234, 2'b11},
    '{1'b1, 13'h1FFF, 16'hBEEF, 2'b01},
    '{1'b0, 13'h1FFF, 16'h0000, 2'b00},
    '{1'b1, 13'h0000, 16'h7766, 2'b10},
    '{1'b0, 13'h0000, 16'h0000, 2'b00},
    '{1'b1, 13'h0ABC, 16'h5555, 2'b00},
    '{1'b0, 13'h0ABC, 16'h0000, 2'b00},
    '{1'b1, 13'h0ABC, 16'h9A9A, 2'b11},
    '{1'b0, 13'h0ABC, 16'h0000, 2'b00},
    '{1'b0, 13'h1FFF, 16'h0000, 2'b00}
  };

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [12:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic reqReady, doneValid, memCeN, memOeN, memDqOe;
  logic [15:0] rspRdata, memDqOut;
  logic [15:0] memDqIn = '0;
  logic [12:0] memAddr;
  logic [1:0]  memWeN;

  asram_ctrl #(.SETUP_CYC(SU), .STROBE_CYC(ST), .HOLD_CYC(HO), .ACCESS_CYC(AC)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .doneValid(doneValid), .rspRdata(rspRdata), .memAddr(memAddr), .memCeN(memCeN),
    .memOeN(memOeN), .memWeN(memWeN), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int errAddr = 0, errBus = 0, errIdle = 0, errDone = 0;
  int low0 = 0, low1 = 0;
  logic [15:0] ram [int];     // pin-level model
  logic [15:0] shadow [int];  // intended contents
  logic [1:0]  prevWe = 2'b11;
  logic [12:0] prevAddr = '0;
  logic        prevDone = 0;

  function automatic logic [15:0] peek(input int a);
    return ram.exists(a) ? ram[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] expect_rd(input int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bus monitor and memory model
  always @(negedge clk) begin
    if (rstN) begin
      if (memWeN != 2'b11 && prevWe != 2'b11 && memAddr != prevAddr) errAddr++;
      if (memDqOe && !memOeN) errBus++;
      if (memWeN != 2'b11 && (memCeN || !memOeN)) errBus++;
      if (reqReady != memCeN) errIdle++;
      if (doneValid && prevDone) errDone++;
      if (!memWeN[0]) low0++;
      if (!memWeN[1]) low1++;
      for (int b = 0; b < 2; b++) begin
        if (!prevWe[b] && memWeN[b]) begin
          if (!memDqOe) errBus++;
          else begin
            logic [15:0] w;
            w = peek(int'(memAddr));
            w[b*8 +: 8] = memDqOut[b*8 +: 8];
            ram[int'(memAddr)] = w;
          end
        end
      end
    end
    memDqIn  <= (!memCeN && !memOeN) ? peek(int'(memAddr)) : 16'h0000;
    prevWe   = memWeN;
    prevAddr = memAddr;
    prevDone = doneValid;
  end

  task automatic access(input vec_t v, output int lat);
    @(negedge clk);
    reqValid = 1; reqWrite = v.wr; reqAddr = v.a; reqWdata = v.d; reqMask = v.m;
    low0 = 0; low1 = 0;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    lat = 0;
    while (!doneValid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    logic [15:0] keep;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", {memCeN, memOeN, memWeN, memDqOe, reqReady, doneValid}, {1'b1,1'b1,2'b11,1'b0,1'b1,1'b0}, "reset pins");
    rstN = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", {memCeN, memOeN, memWeN, memDqOe, reqReady, doneValid}, {1'b1,1'b1,2'b11,1'b0,1'b1,1'b0}, "after reset");

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      access(v, lat);
      if (v.wr) begin
        if (v.m == 2'b00) begin
          chk("R9", lat, 0, "empty-mask latency");
          chk("R9", low0 + low1, 0, "empty-mask strobes");
        end else begin
          chk("R4", lat, SU + ST + HO, "write latency");
          chk("R3", low0, v.m[0] ? ST : 0, "low-byte strobe cycles");
          chk("R3", low1, v.m[1] ? ST : 0, "high-byte strobe cycles");
          begin
            logic [15:0] w;
            w = expect_rd(int'(v.a));
            if (v.m[0]) w[7:0]  = v.d[7:0];
            if (v.m[1]) w[15:8] = v.d[15:8];
            shadow[int'(v.a)] = w;
          end
        end
      end else begin
        chk("R2", lat, AC, "read latency");
        chk("R2", rspRdata, expect_rd(int'(v.a)), "read data");
        chk("R3", low0 + low1, 0, "no strobe on read");
      end
      @(negedge clk);
      chk("R8", doneValid, 0, "done one cycle");
    end

    // R10: read word survives a write
    keep = rspRdata;
    access('{1'b1, 13'h1FFF, 16'h0000, 2'b11}, lat);
    shadow[13'h1FFF] = 16'h0000;
    repeat (2) @(negedge clk);
    chk("R10", rspRdata, keep, "read register after write");
    access('{1'b0, 13'h1FFF, 16'h0000, 2'b00}, lat);
    chk("R10", rspRdata, 16'h0000, "read after overwrite");

    // R9: empty-mask write leaves contents untouched
    access('{1'b1, 13'h0000, 16'hFFFF, 2'b00}, lat);
    access('{1'b0, 13'h0000, 16'h0000, 2'b00}, lat);
    chk("R9", rspRdata, expect_rd(0), "contents after empty mask");

    repeat (3) @(negedge clk);
    chk("R5", errAddr, 0, "address moved under strobe");
    chk("R6", errBus, 0, "bus direction violations");
    chk("R7", errIdle, 0, "select vs idle mismatches");
    chk("R8", errDone, 0, "wide done pulses");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule